// File: doc/BRIEF.md
# Ethernet Port Ingress Traffic Classifier

This block sits at the ingress of one switch port and classifies each arriving frame from its already-parsed header fields: the 48-bit destination MAC, the EtherType found after the source address, and the 16-bit tag control word that follows it. From these it decides whether the frame carries a VLAN tag, which VLAN ID and which of eight traffic classes the frame is given, whether it is trapped to the CPU port, whether it is dropped at ingress, and the set of egress ports it may be forwarded to.

The tag EtherType is held in a register rather than fixed, so software can move it away from 0x8100 to make the port treat ordinary tagged frames as untagged. Frames whose destination MAC falls in either of two management multicast ranges always go to the top traffic class. Two value/mask filters on the destination MAC trap link-local traffic to the CPU. The egress set combines the port's bridge forwarding domain with the member ports of the assigned VLAN, which come from a small table of VLAN slots searched by VID. All configuration is written through a simple write-only register port.

Top module: `port_ingress_classifier`

## Requirements
- R1: A frame is tagged (tagged_o = 1) only when ethtype_i equals the tag-type register (address 0x00, bits [15:0], reset 0x8100); with that register set to any other value, a frame with EtherType 0x8100 is untagged.
- R2: An untagged frame gets vid_o equal to the port default VID (address 0x01, bits [11:0], reset 1) and tc_o equal to the port default class (address 0x01, bits [14:12], reset 0).
- R3: A tagged frame gets vid_o = tci_i[11:0] and tc_o = class_map[tci_i[15:13]], where the class for priority p is held at address 0x03 bits [3p+2:3p]; the map resets to the identity p -> p.
- R4: A frame whose dmac_i[47:24] is 0x0180C2 or 0x01191B gets tc_o = 7 whatever its tag, priority bits or port default.
- R5: Trap filter k (k = 0, 1) holds a 48-bit value at addresses 0x04+4k (bits [31:0]) and 0x05+4k (bits [47:32] in [15:0]) and a 48-bit mask at 0x06+4k and 0x07+4k; it is enabled by address 0x01 bit 17+k (reset off). A frame matches when (dmac_i ^ value) & mask is zero.
- R6: A trapped frame (trap_o = 1) has egress_mask_o holding only the CPU port bit (bit 4 by default) and drop_o = 0, regardless of VLAN membership.
- R7: With VLAN filtering enabled (address 0x01 bit 16, reset off), a non-trapped frame whose assigned VID has no valid slot, or whose slot does not include the ingress port (bit 1 by default), gets drop_o = 1 and egress_mask_o = 0.
- R8: VLAN slot i is written at address 0x10+i: VID in [11:0], member ports in [16+NUM_PORTS-1:16], valid in bit 31; all slots reset invalid.
- R9: For a non-trapped, non-dropped frame, egress_mask_o is the bitwise AND of the forwarding domain (address 0x02, bits [NUM_PORTS-1:0], reset all ones) and the assigned VLAN's member ports, with the ingress port's own bit always cleared.
- R10: Each decision is registered: dec_valid_o is high for exactly the cycle after each cycle hdr_valid_i is high, and back-to-back headers give back-to-back decisions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| hdr_valid_i | input | 1 | Header fields valid this cycle |
| dmac_i | input | 48 | Destination MAC address |
| ethtype_i | input | 16 | EtherType / tag protocol identifier |
| tci_i | input | 16 | Tag control word (priority in [15:13], VID in [11:0]) |
| dec_valid_o | output | 1 | Decision valid strobe |
| tagged_o | output | 1 | Frame recognised as VLAN-tagged |
| vid_o | output | 12 | Assigned VLAN ID |
| tc_o | output | 3 | Assigned traffic class |
| trap_o | output | 1 | Frame trapped to the CPU port |
| drop_o | output | 1 | Frame dropped at ingress |
| egress_mask_o | output | NUM_PORTS | Permitted egress ports |

## Verification
Every result (tag flag, VID, class, trap, drop and egress set) is due on the rising edge after the one that captures hdr_valid_i, so it becomes visible one cycle after the strobe. The bench drives headers on falling edges and reads the outputs on the next falling edge, midway between the capturing edge and the following one. Configuration writes are completed at least a cycle before the header that depends on them, so each decision sees settled register values; a back-to-back pair of headers confirms that each decision lands in its own cycle and that the valid strobe then falls.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int VID_W    = 12;
  localparam int TC_W     = 3;
  localparam int N_PCP    = 8;
  localparam int N_TRAP   = 2;
  localparam int MAC_W    = 48;

  localparam logic [23:0]     MGMT_PFX_A = 24'h0180C2;
  localparam logic [23:0]     MGMT_PFX_B = 24'h01191B;
  localparam logic [TC_W-1:0] TC_MGMT    = 3'd7;

  // register addresses
  localparam int A_TPID   = 0;
  localparam int A_PORT   = 1;
  localparam int A_FWD    = 2;
  localparam int A_PCPMAP = 3;
  localparam int A_TRAP   = 4;   // 4 words per filter
  localparam int A_SLOT   = 16;

  typedef logic [N_PCP-1:0][TC_W-1:0] pcp_map_t;

  typedef struct packed {
    logic             en;
    logic [MAC_W-1:0] val;
    logic [MAC_W-1:0] mask;
  } trap_cfg_t;

  function automatic pcp_map_t pcp_identity();
    pcp_map_t m;
    for (int p = 0; p < N_PCP; p++) m[p] = TC_W'(p);
    return m;
  endfunction
endpackage

// File: rtl/cls_cfg_regs.sv
module cls_cfg_regs
  import cls_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int N_SLOTS   = 8,
  parameter int CFG_AW    = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [CFG_AW-1:0]                   addr_i,
  input  logic [31:0]                         wdata_i,
  output logic [15:0]                         tpid_o,
  output logic [VID_W-1:0]                    pvid_o,
  output logic [TC_W-1:0]                     pprio_o,
  output logic                                filt_en_o,
  output logic [NUM_PORTS-1:0]                fwd_o,
  output pcp_map_t                            pcp_map_o,
  output trap_cfg_t [N_TRAP-1:0]              trap_o,
  output logic [N_SLOTS-1:0]                  slot_valid_o,
  output logic [N_SLOTS-1:0][VID_W-1:0]       slot_vid_o,
  output logic [N_SLOTS-1:0][NUM_PORTS-1:0]   slot_mem_o
);
  function automatic logic hit(input int a);
    return we_i && (addr_i == CFG_AW'(a));
  endfunction

  logic [N_TRAP-1:0] trap_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpid_o    <= 16'h8100;
      pvid_o    <= VID_W'(1);
      pprio_o   <= '0;
      filt_en_o <= 1'b0;
      trap_en_q <= '0;
      fwd_o     <= '1;
      pcp_map_o <= pcp_identity();
    end else begin
      if (hit(A_TPID)) tpid_o <= wdata_i[15:0];
      if (hit(A_PORT)) begin
        pvid_o    <= wdata_i[VID_W-1:0];
        pprio_o   <= wdata_i[14:12];
        filt_en_o <= wdata_i[16];
        trap_en_q <= wdata_i[17 +: N_TRAP];
      end
      if (hit(A_FWD))    fwd_o     <= wdata_i[NUM_PORTS-1:0];
      if (hit(A_PCPMAP)) pcp_map_o <= wdata_i[N_PCP*TC_W-1:0];
    end
  end

  for (genvar k = 0; k < N_TRAP; k++) begin : g_trap
    localparam int BASE = A_TRAP + 4 * k;
    logic [MAC_W-1:0] val_q, mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q  <= '0;
        mask_q <= '0;
      end else begin
        if (hit(BASE))     val_q[31:0]   <= wdata_i;
        if (hit(BASE + 1)) val_q[47:32]  <= wdata_i[15:0];
        if (hit(BASE + 2)) mask_q[31:0]  <= wdata_i;
        if (hit(BASE + 3)) mask_q[47:32] <= wdata_i[15:0];
      end
    end
    assign trap_o[k] = '{en: trap_en_q[k], val: val_q, mask: mask_q};
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_valid_o[i] <= 1'b0;
        slot_vid_o[i]   <= '0;
        slot_mem_o[i]   <= '0;
      end else if (hit(A_SLOT + i)) begin
        slot_valid_o[i] <= wdata_i[31];
        slot_vid_o[i]   <= wdata_i[VID_W-1:0];
        slot_mem_o[i]   <= wdata_i[16 +: NUM_PORTS];
      end
    end
  end
endmodule

// File: rtl/cls_trap_filter.sv
module cls_trap_filter
  import cls_pkg::*;
(
  input  logic [MAC_W-1:0] dmac_i,
  input  trap_cfg_t        cfg_i,
  output logic             hit_o
);
  assign hit_o = cfg_i.en && (((dmac_i ^ cfg_i.val) & cfg_i.mask) == '0);
endmodule

// File: rtl/cls_vlan_table.sv
module cls_vlan_table
  import cls_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int N_SLOTS   = 8
) (
  input  logic [VID_W-1:0]                  vid_i,
  input  logic [N_SLOTS-1:0]                slot_valid_i,
  input  logic [N_SLOTS-1:0][VID_W-1:0]     slot_vid_i,
  input  logic [N_SLOTS-1:0][NUM_PORTS-1:0] slot_mem_i,
  output logic                              hit_o,
  output logic [NUM_PORTS-1:0]              members_o
);
  // lowest matching slot wins
  always_comb begin
    hit_o     = 1'b0;
    members_o = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (slot_valid_i[i] && slot_vid_i[i] == vid_i) begin
        hit_o     = 1'b1;
        members_o = slot_mem_i[i];
      end
    end
  end
endmodule

// File: rtl/port_ingress_classifier.sv
module port_ingress_classifier
  import cls_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_ID   = 1,
  parameter int CPU_PORT  = 4,
  parameter int N_SLOTS   = 8,
  parameter int CFG_AW    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic                 hdr_valid_i,
  input  logic [47:0]          dmac_i,
  input  logic [15:0]          ethtype_i,
  input  logic [15:0]          tci_i,
  output logic                 dec_valid_o,
  output logic                 tagged_o,
  output logic [11:0]          vid_o,
  output logic [2:0]           tc_o,
  output logic                 trap_o,
  output logic                 drop_o,
  output logic [NUM_PORTS-1:0] egress_mask_o
);
  localparam logic [NUM_PORTS-1:0] SELF_BIT = NUM_PORTS'(1) << PORT_ID;
  localparam logic [NUM_PORTS-1:0] CPU_BIT  = NUM_PORTS'(1) << CPU_PORT;

  logic [15:0]                        tpid;
  logic [VID_W-1:0]                   pvid;
  logic [TC_W-1:0]                    pprio;
  logic                               filt_en;
  logic [NUM_PORTS-1:0]               fwd;
  pcp_map_t                           pcp_map;
  trap_cfg_t [N_TRAP-1:0]             trap_cfg;
  logic [N_SLOTS-1:0]                 slot_valid;
  logic [N_SLOTS-1:0][VID_W-1:0]      slot_vid;
  logic [N_SLOTS-1:0][NUM_PORTS-1:0]  slot_mem;

  cls_cfg_regs #(
    .NUM_PORTS(NUM_PORTS), .N_SLOTS(N_SLOTS), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .tpid_o(tpid), .pvid_o(pvid), .pprio_o(pprio), .filt_en_o(filt_en),
    .fwd_o(fwd), .pcp_map_o(pcp_map), .trap_o(trap_cfg),
    .slot_valid_o(slot_valid), .slot_vid_o(slot_vid), .slot_mem_o(slot_mem)
  );

  logic [N_TRAP-1:0] trap_hit;
  for (genvar k = 0; k < N_TRAP; k++) begin : g_flt
    cls_trap_filter u_flt (.dmac_i(dmac_i), .cfg_i(trap_cfg[k]), .hit_o(trap_hit[k]));
  end

  logic             is_tagged, is_mgmt, is_trap, vlan_hit, is_member, is_drop;
  logic [VID_W-1:0] vid_d;
  logic [TC_W-1:0]  tc_d;
  logic [NUM_PORTS-1:0] vlan_mem, egr_d;

  assign is_tagged = (ethtype_i == tpid);
  assign vid_d     = is_tagged ? tci_i[11:0] : pvid;
  assign is_mgmt   = (dmac_i[47:24] == MGMT_PFX_A) || (dmac_i[47:24] == MGMT_PFX_B);

  always_comb begin
    if (is_mgmt)        tc_d = TC_MGMT;
    else if (is_tagged) tc_d = pcp_map[tci_i[15:13]];
    else                tc_d = pprio;
  end

  cls_vlan_table #(.NUM_PORTS(NUM_PORTS), .N_SLOTS(N_SLOTS)) u_vtab (
    .vid_i(vid_d), .slot_valid_i(slot_valid), .slot_vid_i(slot_vid),
    .slot_mem_i(slot_mem), .hit_o(vlan_hit), .members_o(vlan_mem)
  );

  assign is_trap   = |trap_hit;
  assign is_member = vlan_hit && vlan_mem[PORT_ID];
  assign is_drop   = !is_trap && filt_en && !is_member;

  always_comb begin
    if (is_trap)      egr_d = CPU_BIT;
    else if (is_drop) egr_d = '0;
    else              egr_d = fwd & vlan_mem & ~SELF_BIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o   <= 1'b0;
      tagged_o      <= 1'b0;
      vid_o         <= '0;
      tc_o          <= '0;
      trap_o        <= 1'b0;
      drop_o        <= 1'b0;
      egress_mask_o <= '0;
    end else begin
      dec_valid_o <= hdr_valid_i;
      if (hdr_valid_i) begin
        tagged_o      <= is_tagged;
        vid_o         <= vid_d;
        tc_o          <= tc_d;
        trap_o        <= is_trap;
        drop_o        <= is_drop;
        egress_mask_o <= egr_d;
      end
    end
  end
endmodule

// File: rtl/cls_chk.sv
module cls_chk #(
  parameter int NUM_PORTS = 5,
  parameter int PORT_ID   = 1,
  parameter int CPU_PORT  = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 hdr_valid_i,
  input logic [47:0]          dmac_i,
  input logic                 dec_valid_o,
  input logic [2:0]           tc_o,
  input logic                 trap_o,
  input logic                 drop_o,
  input logic [NUM_PORTS-1:0] egress_mask_o
);
  localparam logic [NUM_PORTS-1:0] CPU_BIT = NUM_PORTS'(1) << CPU_PORT;

  // R10
  dec_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> dec_valid_o);
  // R10
  dec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_i |=> !dec_valid_o);
  // R9
  self_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> !egress_mask_o[PORT_ID]);
  // R6
  trap_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && trap_o) |-> (egress_mask_o == CPU_BIT && !drop_o));
  // R7
  drop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && drop_o) |-> (egress_mask_o == '0));
  // R4
  mgmt_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && (dmac_i[47:24] == 24'h0180C2 || dmac_i[47:24] == 24'h01191B))
      |=> (tc_o == 3'd7));
endmodule

bind port_ingress_classifier cls_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_ID(PORT_ID), .CPU_PORT(CPU_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hdr_valid_i(hdr_valid_i), .dmac_i(dmac_i),
  .dec_valid_o(dec_valid_o), .tc_o(tc_o), .trap_o(trap_o), .drop_o(drop_o),
  .egress_mask_o(egress_mask_o)
);

// File: tb/port_ingress_classifier_tb.sv
module port_ingress_classifier_tb;
  localparam int NP = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [4:0]    cfg_addr_i = '0;
  logic [31:0]   cfg_wdata_i = '0;
  logic          hdr_valid_i = 1'b0;
  logic [47:0]   dmac_i = '0;
  logic [15:0]   ethtype_i = '0;
  logic [15:0]   tci_i = '0;
  logic          dec_valid_o, tagged_o, trap_o, drop_o;
  logic [11:0]   vid_o;
  logic [2:0]    tc_o;
  logic [NP-1:0] egress_mask_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  port_ingress_classifier u_dut (.*);

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 5'(a); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_port(input int pvid, input int prio, input bit filt,
                          input bit t0, input bit t1);
    wr(1, 32'(pvid) | (32'(prio) << 12) | (32'(filt) << 16) |
          (32'(t0) << 17) | (32'(t1) << 18));
  endtask

  // drive one header, return at the falling edge where its decision is visible
  task automatic send(input logic [47:0] da, input logic [15:0] et, input logic [15:0] tci);
    @(negedge clk_i);
    hdr_valid_i = 1'b1; dmac_i = da; ethtype_i = et; tci_i = tci;
    @(negedge clk_i);
    hdr_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset dec_valid", dec_valid_o, 0);
    chk("R9 reset egress", egress_mask_o, 0);
  endtask

  task automatic t_untagged;
    wr(16, 32'h8000_0000 | (32'h1F << 16) | 32'd1);   // slot0: vid 1, all members
    set_port(1, 5, 0, 0, 0);
    send(48'h0000_1111_2222, 16'h0800, 16'hFFFF);
    chk("R10 dec_valid", dec_valid_o, 1);
    chk("R2 untagged flag", tagged_o, 0);
    chk("R2 default vid", vid_o, 1);
    chk("R2 default class", tc_o, 5);
    chk("R9 egress fwd&members minus self", egress_mask_o, 5'b11101);
  endtask

  task automatic t_tagged;
    logic [23:0] m;
    send(48'h0000_1111_2222, 16'h8100, 16'hC001);
    chk("R3 tagged flag", tagged_o, 1);
    chk("R3 vid from tci", vid_o, 1);
    chk("R3 identity class", tc_o, 6);
    m = '0;
    for (int p = 0; p < 8; p++) m |= 24'((p == 6) ? 2 : p) << (3 * p);
    wr(3, {8'h0, m});
    send(48'h0000_1111_2222, 16'h8100, 16'hC001);
    chk("R3 remapped class", tc_o, 2);
  endtask

  task automatic t_tpid;
    wr(0, 32'h9100);
    send(48'h0000_1111_2222, 16'h8100, 16'hC005);
    chk("R1 0x8100 untagged after tpid change", tagged_o, 0);
    chk("R1 default vid", vid_o, 1);
    chk("R1 default class", tc_o, 5);
    send(48'h0000_1111_2222, 16'h9100, 16'h2001);
    chk("R1 custom tpid tagged", tagged_o, 1);
    chk("R1 class via map", tc_o, 1);
    wr(0, 32'h8100);
  endtask

  task automatic t_mgmt;
    send(48'h0180_C200_000E, 16'h8100, 16'h0001);
    chk("R4 prefix A class", tc_o, 7);
    chk("R4 still tagged", tagged_o, 1);
    send(48'h0119_1B00_0000, 16'h0800, 16'h0000);
    chk("R4 prefix B class", tc_o, 7);
    send(48'h0180_C300_0000, 16'h0800, 16'h0000);
    chk("R4 non-mgmt default class", tc_o, 5);
  endtask

  task automatic t_trap;
    wr(4, 32'hC200_0000); wr(5, 32'h0180);
    wr(6, 32'hFFFF_FFF0); wr(7, 32'hFFFF);
    wr(8, 32'h0000_00AA); wr(9, 32'h0200);
    wr(10, 32'hFFFF_FFFF); wr(11, 32'hFFFF);
    send(48'h0180_C200_0003, 16'h0800, 16'h0000);
    chk("R5 disabled filter no trap", trap_o, 0);
    chk("R5 disabled filter egress", egress_mask_o, 5'b11101);
    set_port(1, 5, 1, 1, 0);
    send(48'h0180_C200_0003, 16'h8100, 16'h0063);
    chk("R5 masked match traps", trap_o, 1);
    chk("R6 trap egress cpu only", egress_mask_o, 5'b10000);
    chk("R6 trap not dropped", drop_o, 0);
    set_port(1, 5, 0, 0, 1);
    send(48'h0200_0000_00AA, 16'h0800, 16'h0000);
    chk("R5 filter1 exact match", trap_o, 1);
    send(48'h0200_0000_00AB, 16'h0800, 16'h0000);
    chk("R5 filter1 miss", trap_o, 0);
    chk("R5 miss egress", egress_mask_o, 5'b11101);
  endtask

  task automatic t_filter;
    wr(2, 32'b11001);
    wr(17, 32'h8000_0000 | (32'b10100 << 16) | 32'd5);
    wr(18, 32'h8000_0000 | (32'b01111 << 16) | 32'd7);
    set_port(1, 5, 1, 0, 0);
    send(48'h0000_1111_2222, 16'h8100, 16'h0005);
    chk("R7 non-member drop", drop_o, 1);
    chk("R7 drop egress empty", egress_mask_o, 0);
    send(48'h0000_1111_2222, 16'h8100, 16'h0007);
    chk("R8 member accepted", drop_o, 0);
    chk("R9 egress and", egress_mask_o, 5'b01001);
    send(48'h0000_1111_2222, 16'h8100, 16'h0009);
    chk("R7 unknown vid drop", drop_o, 1);
    set_port(1, 5, 0, 0, 0);
    send(48'h0000_1111_2222, 16'h8100, 16'h0009);
    chk("R7 filter off no drop", drop_o, 0);
    chk("R8 unknown vid no members", egress_mask_o, 0);
  endtask

  task automatic t_timing;
    @(negedge clk_i);
    hdr_valid_i = 1'b1; dmac_i = 48'h0000_1111_2222; ethtype_i = 16'h8100; tci_i = 16'h0007;
    @(negedge clk_i);
    chk("R10 first decision", dec_valid_o, 1);
    chk("R10 first vid", vid_o, 7);
    tci_i = 16'h0005;
    @(negedge clk_i);
    hdr_valid_i = 1'b0;
    chk("R10 second decision", dec_valid_o, 1);
    chk("R10 second vid", vid_o, 5);
    @(negedge clk_i);
    chk("R10 strobe falls", dec_valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_untagged();
    t_tagged();
    t_tpid();
    t_mgmt();
    t_trap();
    t_filter();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule